// File: doc/BRIEF.md
# Cycle-Start Request Generator

This block decides when a node acting as cycle master should put a cycle-start packet on the bus. An external cycle timer supplies a one-cycle pulse each time its cycle count advances. When the cycle-master enable is on, the node is the bus root and the transmitter is enabled, each such pulse raises a request to the transmitter. The request stays raised until the transmitter acknowledges it.

A cycle-timeout pulse shuts the function down. After a timeout the block raises a disabled flag and issues no more requests. Holding the enable high does not bring the function back. Software must first drop the enable, which also clears the disabled flag, and then raise it again.

Losing the root role cancels an outstanding request. So do a transmitter reset and a cleared transmitter enable. Building the packet and running the cycle timer are left to neighbouring blocks.

Top module: `cyc_start_gen`

## Requirements
- R1: Reset is synchronous and active low. During reset and in the first cycle after it, `start_req` and `cm_disabled` are both 0.
- R2: A `cnt_tick` pulse produces `start_req` = 1 on the next cycle when all of the following hold in the pulse's cycle: the function is armed, `is_root` = 1, `tx_en` = 1, `tx_rst` = 0 and `cyc_tmo` = 0.
- R3: A `cnt_tick` produces no request in any of these cases: the function is not armed, `is_root` = 0, or `tx_en` = 0. The function arms in the cycle after `cm_en` is first seen high, so a tick in that same cycle is not honoured.
- R4: Once raised, `start_req` stays at 1 until a cycle with `start_ack` = 1. It is 0 from the following cycle, unless a new `cnt_tick` arrives in the acknowledge cycle, in which case the new request takes priority.
- R5: While the function is armed and `cm_en` = 1, a `cyc_tmo` pulse sets `cm_disabled` = 1 on the next cycle and cancels any outstanding request in the same step.
- R6: While `cm_disabled` = 1 and `cm_en` stays 1, no request is ever issued. In the cycle after `cm_en` is seen at 0, `cm_disabled` returns to 0. Requests then resume only after `cm_en` is raised again.
- R7: A cycle with `is_root` = 0 cancels an outstanding request: `start_req` is 0 from the next cycle.
- R8: A cycle with `tx_rst` = 1 or `tx_en` = 0 cancels an outstanding request and blocks a new one in that cycle.
- R9: A `cyc_tmo` pulse while `cm_en` = 0 is ignored: `cm_disabled` stays 0, and a later enable arms the function normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cm_en | input | 1 | Cycle-master enable from software |
| is_root | input | 1 | This node is currently the bus root |
| cnt_tick | input | 1 | One-cycle pulse: the cycle count advanced |
| cyc_tmo | input | 1 | One-cycle pulse: cycle timeout detected |
| tx_en | input | 1 | Transmitter enable control |
| tx_rst | input | 1 | Synchronous transmitter reset control |
| start_ack | input | 1 | Transmitter accepted the cycle-start request |
| start_req | output | 1 | Cycle-start send request, held until acknowledged |
| cm_disabled | output | 1 | Sticky flag: function shut down by a timeout |

## Verification
The request path is swept over every combination of root, tick, transmitter enable, transmitter reset, timeout and acknowledge, starting with no request outstanding and again with one outstanding. Each result is compared with an arithmetic model in which cancel beats a new tick and a new tick beats an acknowledge. This sweep separates the three priorities and shows which controls gate new requests and which only cancel old ones. Directed sequences cover the rest:
- a tick in the same cycle the enable rises;
- a timeout followed by ticks while the enable is held high, which tells a sticky shutdown apart from a one-cycle suppression;
- the clear-then-set recovery;
- a timeout while the enable is low.

// File: rtl/cyc_start_pkg.sv
// Package: shared types for the cycle-start request generator.
// Assumes: nothing beyond IEEE 1800-2017.
package cyc_start_pkg;

    // Arming state of the cycle-master function
    typedef enum logic [1:0] {
        ARM_IDLE    = 2'd0,  // enable low, function off
        ARM_RUN     = 2'd1,  // enable high, function live
        ARM_TRIPPED = 2'd2   // shut down by timeout, waiting for enable low
    } arm_state_e;

endpackage

// File: rtl/cyc_arm_fsm.sv
// Module: cyc_arm_fsm
// Tracks whether the cycle-master function is live. It arms one cycle
// after the enable is seen high. A timeout while live moves it to a
// tripped state, which it leaves only when the enable is seen low.
// Assumes: cm_en and cyc_tmo are synchronous to clk.
module cyc_arm_fsm
    import cyc_start_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cm_en,
    input  logic cyc_tmo,
    output logic armed,
    output logic tripped
);

    arm_state_e state_q, state_d;

    // Next-state decode for the arming sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE:    if (cm_en) state_d = ARM_RUN;
            ARM_RUN:     if (!cm_en) state_d = ARM_IDLE;
                         else if (cyc_tmo) state_d = ARM_TRIPPED;
            ARM_TRIPPED: if (!cm_en) state_d = ARM_IDLE;
            default:     state_d = ARM_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_IDLE;
        else        state_q <= state_d;
    end

    assign armed   = (state_q == ARM_RUN);
    assign tripped = (state_q == ARM_TRIPPED);

    // R5: timeout while live trips the function
    p_tmo_trips_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cm_en && cyc_tmo) |=> tripped);

    // R6: tripped state survives while enable stays high
    p_trip_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && cm_en) |=> tripped);

    // R6: enable low always clears the tripped state
    p_trip_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cm_en) |=> !tripped);

    // R9: timeout with enable low never trips
    p_tmo_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cm_en && cyc_tmo) |=> !tripped);

    // Never live and tripped at once
    p_state_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && tripped));

endmodule

// File: rtl/cyc_req_ctrl.sv
// Module: cyc_req_ctrl
// Holds the outstanding cycle-start request. A cycle-count tick sets it
// when the function is live, the node is root and the transmitter may
// send. Cancel conditions beat a new tick, and a new tick beats an
// acknowledge.
// Assumes: armed comes from a registered arming state.
module cyc_req_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic is_root,
    input  logic cnt_tick,
    input  logic cyc_tmo,
    input  logic tx_en,
    input  logic tx_rst,
    input  logic start_ack,
    output logic pending
);

    logic cancel;
    logic launch;

    // Conditions that wipe the request regardless of a tick
    always_comb begin
        cancel = !armed || !is_root || !tx_en || tx_rst || cyc_tmo;
        launch = cnt_tick && !cancel;
    end

    // Pending-request register
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= 1'b0;
        else if (cancel)    pending <= 1'b0;
        else if (launch)    pending <= 1'b1;
        else if (start_ack) pending <= 1'b0;
    end

    // R2: qualified tick yields a request next cycle
    p_tick_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && is_root && tx_en && !tx_rst && !cyc_tmo && cnt_tick) |=> pending);

    // R4: request held until acknowledged
    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && armed && is_root && tx_en && !tx_rst && !cyc_tmo && !start_ack) |=> pending);

    // R4: acknowledge without new tick drops the request
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ack && !cnt_tick) |=> !pending);

    // R7: loss of root cancels
    p_root_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_root) |=> !pending);

    // R8: transmitter reset or disable cancels
    p_tx_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rst || !tx_en) |=> !pending);

endmodule

// File: rtl/cyc_start_gen.sv
// Module: cyc_start_gen (top)
// Cycle-master start generator. It raises a cycle-start request on each
// cycle-count advance while enabled, root, and allowed to transmit. A
// timeout shuts it down until the enable is cleared and set again.
// Assumes: all inputs are synchronous to clk; tick and timeout are
// single-cycle pulses.
module cyc_start_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic cm_en,
    input  logic is_root,
    input  logic cnt_tick,
    input  logic cyc_tmo,
    input  logic tx_en,
    input  logic tx_rst,
    input  logic start_ack,
    output logic start_req,
    output logic cm_disabled
);

    logic armed;
    logic tripped;
    logic pending;

    // Arming sequence and timeout shutdown
    cyc_arm_fsm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cm_en   (cm_en),
        .cyc_tmo (cyc_tmo),
        .armed   (armed),
        .tripped (tripped)
    );

    // Outstanding request tracking
    cyc_req_ctrl u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .is_root   (is_root),
        .cnt_tick  (cnt_tick),
        .cyc_tmo   (cyc_tmo),
        .tx_en     (tx_en),
        .tx_rst    (tx_rst),
        .start_ack (start_ack),
        .pending   (pending)
    );

    assign start_req   = pending;
    assign cm_disabled = tripped;

    // R6: no request while disabled
    p_no_req_tripped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cm_disabled |-> !start_req);

    // R5: timeout while live clears the request and sets the flag
    p_tmo_kills_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cm_en && cyc_tmo) |=> (cm_disabled && !start_req));

    // R3: a request needs the previous cycle to have been live
    p_req_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed) |=> !start_req);

endmodule

// File: tb/cyc_start_gen_tb.sv
module cyc_start_gen_tb;

    logic clk = 1'b0;
    logic rst_n, cm_en, is_root, cnt_tick, cyc_tmo, tx_en, tx_rst, start_ack;
    logic start_req, cm_disabled;
    int   n_run  = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    cyc_start_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cm_en(cm_en), .is_root(is_root),
        .cnt_tick(cnt_tick), .cyc_tmo(cyc_tmo), .tx_en(tx_en),
        .tx_rst(tx_rst), .start_ack(start_ack),
        .start_req(start_req), .cm_disabled(cm_disabled)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Inputs change at negedge; step waits one active edge, samples at negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cnt_tick = 0; cyc_tmo = 0; tx_rst = 0; start_ack = 0;
        is_root = 1; tx_en = 1;
    endtask

    // Clear-then-set the enable so the function is live with no request
    task automatic rearm();
        idle_inputs();
        cm_en = 0; step();
        cm_en = 1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-reqs actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; cm_en = 0;
        idle_inputs();
        @(negedge clk);
        step(); step();
        chk("R1", "req in reset", start_req, 1'b0);
        chk("R1", "dis in reset", cm_disabled, 1'b0);
        rst_n = 1; step();
        chk("R1", "req after reset", start_req, 1'b0);
        chk("R1", "dis after reset", cm_disabled, 1'b0);

        // R3: a tick in the same cycle the enable rises is not honoured
        cm_en = 1; cnt_tick = 1; step();
        chk("R3", "tick at enable rise", start_req, 1'b0);
        cnt_tick = 1; step(); cnt_tick = 0;
        chk("R2", "tick when live", start_req, 1'b1);
        repeat (3) step();
        chk("R4", "held without ack", start_req, 1'b1);
        start_ack = 1; step(); start_ack = 0;
        chk("R4", "cleared by ack", start_req, 1'b0);

        // Sweep: prior request p, inputs {root,tick,txen,txrst,tmo,ack}
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 64; c++) begin
                logic r, t, e, x, o, a, cancel, exp_req;
                r = c[5]; t = c[4]; e = c[3]; x = c[2]; o = c[1]; a = c[0];
                rearm();
                if (p == 1) begin
                    cnt_tick = 1; step(); cnt_tick = 0;
                    chk("R2", "sweep prime", start_req, 1'b1);
                end
                is_root = r; cnt_tick = t; tx_en = e; tx_rst = x; cyc_tmo = o; start_ack = a;
                step();
                cancel  = !r || !e || x || o;
                exp_req = cancel ? 1'b0 : (t ? 1'b1 : (a ? 1'b0 : p[0]));
                if (o)           chk("R5", "sweep req on tmo", start_req, exp_req);
                else if (!r)     chk("R7", "sweep req no root", start_req, exp_req);
                else if (x || !e) chk("R8", "sweep req tx gate", start_req, exp_req);
                else             chk("R4", "sweep req ack/tick", start_req, exp_req);
                chk("R5", "sweep disabled", cm_disabled, o);
            end
        end

        // R6: sticky shutdown while enable held high
        rearm();
        cyc_tmo = 1; step(); cyc_tmo = 0;
        chk("R5", "tmo sets flag", cm_disabled, 1'b1);
        for (int k = 0; k < 4; k++) begin
            cnt_tick = 1; step();
            chk("R6", "no req while tripped", start_req, 1'b0);
            chk("R6", "flag sticky", cm_disabled, 1'b1);
        end
        cnt_tick = 0;
        cm_en = 0; step();
        chk("R6", "flag cleared by enable low", cm_disabled, 1'b0);
        cnt_tick = 1; step(); cnt_tick = 0;
        chk("R3", "no req with enable low", start_req, 1'b0);
        cm_en = 1; step();
        cnt_tick = 1; step(); cnt_tick = 0;
        chk("R6", "req after re-arm", start_req, 1'b1);

        // R9: timeout with enable low is ignored
        cm_en = 0; step();
        cyc_tmo = 1; step(); cyc_tmo = 0;
        chk("R9", "flag stays clear", cm_disabled, 1'b0);
        cm_en = 1; step();
        cnt_tick = 1; step(); cnt_tick = 0;
        chk("R9", "arms normally after", start_req, 1'b1);

        // R3: not root and transmitter disabled both block new ticks
        start_ack = 1; step(); start_ack = 0;
        is_root = 0; cnt_tick = 1; step();
        chk("R3", "no req when not root", start_req, 1'b0);
        is_root = 1; tx_en = 0; step();
        chk("R3", "no req when tx off", start_req, 1'b0);
        cnt_tick = 0; tx_en = 1;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule